// File: doc/BRIEF.md
# Conflict-Miss Victim Buffer

This block is a small, fully associative line store placed next to a direct-mapped data cache. Each line the cache throws out is parked here. When the cache later misses, the same request is presented to this buffer. Every entry compares its stored line address against the request at once, and the answer comes back in the same cycle. A match hands the line, with its dirty state, straight back to the cache. A conflict miss is then served locally and does not travel to the lower level.

Lines enter only through the eviction port. When the cache refills from the buffer, it usually discards a line of its own in the same cycle. That discarded line is written into the entry the returning line just vacated, so the two lines trade places. When an insert finds every entry occupied, the least recently used entry makes room. If that entry is dirty, it goes out on the writeback port one cycle later. A clean entry is simply overwritten. An entry stores the full line address, meaning the cache tag and the cache index together, because any line can occupy any entry.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty: no lookup hits and `wb_valid` is low.
- R2: A lookup that matches a stored line raises `lookup_hit` in the same cycle and returns that line's data and dirty flag on `lookup_data` and `lookup_dirty`.
- R3: A match needs both the tag and the index to be equal. A lookup that shares only one of the two fields with a stored line misses.
- R4: An insert goes to an empty entry while one exists. No writeback is raised while fewer than 4 lines are held.
- R5: An insert into a full buffer replaces the line that was inserted or swapped in least recently. After that, a lookup of the replaced line misses.
- R6: When the replaced line is dirty, `wb_valid` is high in the cycle after the insert, and `wb_tag`, `wb_index` and `wb_data` carry that line's address and data. When the replaced line is clean, `wb_valid` stays low.
- R7: A lookup hit together with an insert in the same cycle is a swap. The hit line is returned, the inserted line takes its entry and becomes the most recently used, no writeback follows, and no other line is lost.
- R8: A lookup hit without an insert removes the returned line, so a second lookup of it misses.
- R9: While `lookup_valid` is low, `lookup_hit` stays low and no stored line is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | A line discarded by the cache is to be inserted |
| evict_tag | input | TAG_W | Tag of the inserted line |
| evict_index | input | IDX_W | Cache index of the inserted line |
| evict_data | input | LINE_W | Data of the inserted line |
| evict_dirty | input | 1 | Inserted line differs from memory |
| lookup_valid | input | 1 | Lookup request after a cache miss |
| lookup_tag | input | TAG_W | Tag searched for |
| lookup_index | input | IDX_W | Index searched for |
| lookup_hit | output | 1 | A stored line matches (same cycle) |
| lookup_data | output | LINE_W | Data of the matching line |
| lookup_dirty | output | 1 | Dirty flag of the matching line |
| wb_valid | output | 1 | A dirty line left the buffer |
| wb_tag | output | TAG_W | Tag of the written-back line |
| wb_index | output | IDX_W | Index of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
The bench targets the replacement order after a mix of swaps, removals and fresh inserts. A design with broken age bookkeeping would throw out a recently swapped-in line and keep a stale one, and a later lookup would miss where a hit was due. Partial-address aliases, with the same tag at another index and the same index with another tag, catch a comparator that checks only one field. Swaps are checked for a spurious writeback and for a lost neighbour. Lookups with the request line low confirm that a design which consumes entries on an idle request is caught.

// File: rtl/vb_pkg.sv
package vb_pkg;
   // what an insert does to the entry it lands on
   typedef enum logic [1:0] {
      INS_NONE = 2'd0,
      INS_FREE = 2'd1,
      INS_LRU  = 2'd2,
      INS_SWAP = 2'd3
   } ins_kind_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26
) (
   input  logic                             req,
   input  logic [ADDR_W-1:0]                key,
   input  logic [ENTRIES-1:0]               vld,
   input  logic [ENTRIES-1:0][ADDR_W-1:0]   addr,
   output logic [ENTRIES-1:0]               hit_oh
);
   // one comparator per entry, all evaluated together
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_oh[i] = req & vld[i] & (addr[i] == key);
   end
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
   parameter int ENTRIES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch_en,
   input  logic [ENTRIES-1:0] touch_oh,
   input  logic               drop_en,
   input  logic [ENTRIES-1:0] drop_oh,
   output logic [ENTRIES-1:0] oldest_oh
);
   localparam int AGE_W = $clog2(ENTRIES);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ENTRIES - 1);

   logic [ENTRIES-1:0][AGE_W-1:0] age_q, age_d;
   logic [AGE_W-1:0] touch_age, drop_age;

   always_comb begin
      touch_age = '0;
      drop_age  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (touch_oh[i]) touch_age = touch_age | age_q[i];
         if (drop_oh[i])  drop_age  = drop_age  | age_q[i];
      end
   end

   always_comb begin
      age_d = age_q;
      for (int i = 0; i < ENTRIES; i++) begin
         if (touch_en) begin
            if (touch_oh[i])                age_d[i] = '0;
            else if (age_q[i] < touch_age)  age_d[i] = age_q[i] + 1'b1;
         end else if (drop_en) begin
            if (drop_oh[i])                 age_d[i] = AGE_MAX;
            else if (age_q[i] > drop_age)   age_d[i] = age_q[i] - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= AGE_W'(i);
      end else begin
         age_q <= age_d;
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_old
      assign oldest_oh[i] = (age_q[i] == AGE_MAX);
   end

   // R5
   oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(oldest_oh));
endmodule

// File: rtl/vb_store.sv
module vb_store #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   parameter int LINE_W  = 128
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ENTRIES-1:0]               wr_oh,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [LINE_W-1:0]                wr_data,
   input  logic                             wr_dirty,
   input  logic [ENTRIES-1:0]               clr_oh,
   output logic [ENTRIES-1:0]               vld,
   output logic [ENTRIES-1:0][ADDR_W-1:0]   addr,
   output logic [ENTRIES-1:0][LINE_W-1:0]   data,
   output logic [ENTRIES-1:0]               dirty
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[i]   <= 1'b0;
            dirty[i] <= 1'b0;
         end else if (wr_oh[i]) begin
            vld[i]   <= 1'b1;
            dirty[i] <= wr_dirty;
         end else if (clr_oh[i]) begin
            vld[i]   <= 1'b0;
            dirty[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_oh[i]) begin
            addr[i] <= wr_addr;
            data[i] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 18,
   parameter int IDX_W   = 8,
   parameter int LINE_W  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evict_valid,
   input  logic [TAG_W-1:0]  evict_tag,
   input  logic [IDX_W-1:0]  evict_index,
   input  logic [LINE_W-1:0] evict_data,
   input  logic              evict_dirty,
   input  logic              lookup_valid,
   input  logic [TAG_W-1:0]  lookup_tag,
   input  logic [IDX_W-1:0]  lookup_index,
   output logic              lookup_hit,
   output logic [LINE_W-1:0] lookup_data,
   output logic              lookup_dirty,
   output logic              wb_valid,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [IDX_W-1:0]  wb_index,
   output logic [LINE_W-1:0] wb_data
);
   import vb_pkg::*;

   localparam int ADDR_W = TAG_W + IDX_W;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (TAG_W < 1 || IDX_W < 1 || LINE_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   logic [ENTRIES-1:0]             vld, dirty, hit_oh, free_oh, oldest_oh;
   logic [ENTRIES-1:0]             tgt_oh, wr_oh, clr_oh;
   logic [ENTRIES-1:0][ADDR_W-1:0] addr;
   logic [ENTRIES-1:0][LINE_W-1:0] data;
   logic [ADDR_W-1:0]              key, evict_addr, old_addr;
   logic [LINE_W-1:0]              old_data;
   logic                           full, spill, old_dirty;
   ins_kind_e                      kind;

   assign key        = {lookup_tag, lookup_index};
   assign evict_addr = {evict_tag, evict_index};

   vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
      .req    (lookup_valid),
      .key    (key),
      .vld    (vld),
      .addr   (addr),
      .hit_oh (hit_oh)
   );

   // matching line mux
   always_comb begin
      lookup_data  = '0;
      lookup_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_oh[i]) begin
            lookup_data  = lookup_data | data[i];
            lookup_dirty = lookup_dirty | dirty[i];
         end
      end
   end
   assign lookup_hit = |hit_oh;

   // lowest empty entry
   always_comb begin
      free_oh = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld[i]) free_oh = ENTRIES'(1) << i;
      end
   end
   assign full = &vld;

   // line that an insert into a full buffer pushes out
   always_comb begin
      old_addr  = '0;
      old_data  = '0;
      old_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (oldest_oh[i]) begin
            old_addr  = old_addr | addr[i];
            old_data  = old_data | data[i];
            old_dirty = old_dirty | dirty[i];
         end
      end
   end

   always_comb begin
      if (!evict_valid)     kind = INS_NONE;
      else if (lookup_hit)  kind = INS_SWAP;
      else if (!full)       kind = INS_FREE;
      else                  kind = INS_LRU;
   end

   always_comb begin
      unique case (kind)
         INS_SWAP: tgt_oh = hit_oh;
         INS_FREE: tgt_oh = free_oh;
         INS_LRU:  tgt_oh = oldest_oh;
         default:  tgt_oh = '0;
      endcase
   end

   assign wr_oh  = tgt_oh;
   assign clr_oh = (lookup_hit && !evict_valid) ? hit_oh : '0;
   assign spill  = (kind == INS_LRU) && old_dirty;

   vb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_oh    (wr_oh),
      .wr_addr  (evict_addr),
      .wr_data  (evict_data),
      .wr_dirty (evict_dirty),
      .clr_oh   (clr_oh),
      .vld      (vld),
      .addr     (addr),
      .data     (data),
      .dirty    (dirty)
   );

   vb_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (evict_valid),
      .touch_oh  (tgt_oh),
      .drop_en   (lookup_hit && !evict_valid),
      .drop_oh   (hit_oh),
      .oldest_oh (oldest_oh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wb_valid <= 1'b0;
      else        wb_valid <= spill;
   end

   always_ff @(posedge clk) begin
      if (spill) begin
         {wb_tag, wb_index} <= old_addr;
         wb_data            <= old_data;
      end
   end

   // R3
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_oh));

   // R9
   idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_valid |-> !lookup_hit);

   // R7
   swap_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_hit && evict_valid) |=> !wb_valid);

   // R6
   wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(evict_valid && !lookup_hit));
endmodule

// File: tb/sim_victim_buffer.sv
module sim_victim_buffer;
   localparam int NENT   = 4;
   localparam int TAG_W  = 18;
   localparam int IDX_W  = 8;
   localparam int LINE_W = 128;
   localparam int ADDR_W = TAG_W + IDX_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic evict_valid = 1'b0, evict_dirty = 1'b0, lookup_valid = 1'b0;
   logic [TAG_W-1:0]  evict_tag = '0, lookup_tag = '0, wb_tag;
   logic [IDX_W-1:0]  evict_index = '0, lookup_index = '0, wb_index;
   logic [LINE_W-1:0] evict_data = '0, lookup_data, wb_data;
   logic lookup_hit, lookup_dirty, wb_valid;

   always #4 clk = ~clk;

   victim_buffer #(.ENTRIES(NENT), .TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .evict_valid(evict_valid), .evict_tag(evict_tag), .evict_index(evict_index),
      .evict_data(evict_data), .evict_dirty(evict_dirty),
      .lookup_valid(lookup_valid), .lookup_tag(lookup_tag), .lookup_index(lookup_index),
      .lookup_hit(lookup_hit), .lookup_data(lookup_data), .lookup_dirty(lookup_dirty),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_index(wb_index), .wb_data(wb_data)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference: list in recency order, index 0 most recent
   logic [ADDR_W-1:0] m_addr [NENT];
   logic [LINE_W-1:0] m_data [NENT];
   bit                m_dirty[NENT];
   int                m_n = 0;
   bit                exp_wbv = 1'b0;
   logic [ADDR_W-1:0] exp_wba = '0;
   logic [LINE_W-1:0] exp_wbd = '0;

   function automatic logic [ADDR_W-1:0] pa(int k);
      return {TAG_W'(k + 1), IDX_W'(k % 3)};
   endfunction

   function automatic int m_find(logic [ADDR_W-1:0] a);
      for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return i;
      return -1;
   endfunction

   task automatic m_remove(int h);
      for (int i = h; i < m_n - 1; i++) begin
         m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1]; m_dirty[i] = m_dirty[i+1];
      end
      m_n--;
   endtask

   task automatic m_push(logic [ADDR_W-1:0] a, logic [LINE_W-1:0] d, bit dy);
      for (int i = m_n; i > 0; i--) begin
         m_addr[i] = m_addr[i-1]; m_data[i] = m_data[i-1]; m_dirty[i] = m_dirty[i-1];
      end
      m_addr[0] = a; m_data[0] = d; m_dirty[0] = dy;
      m_n++;
   endtask

   task automatic chk(bit ok, string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(bit lv, logic [ADDR_W-1:0] la, bit ev, logic [ADDR_W-1:0] ea, bit ed, string lbl);
      logic [LINE_W-1:0] edat = {$urandom, $urandom, $urandom, $urandom};
      int h;
      string wl;
      @(negedge clk);
      lookup_valid = lv; {lookup_tag, lookup_index} = la;
      evict_valid = ev; {evict_tag, evict_index} = ea; evict_data = edat; evict_dirty = ed;
      #1;
      wl = (lbl == "R4" || lbl == "R7" || lbl == "R1") ? lbl : "R6";
      chk(wb_valid === exp_wbv, wl, "wb_valid", LINE_W'(wb_valid), LINE_W'(exp_wbv));
      if (exp_wbv) begin
         chk({wb_tag, wb_index} === exp_wba, wl, "wb address", LINE_W'({wb_tag, wb_index}), LINE_W'(exp_wba));
         chk(wb_data === exp_wbd, wl, "wb data", wb_data, exp_wbd);
      end
      h = lv ? m_find(la) : -1;
      chk(lookup_hit === (h >= 0), lbl, "lookup_hit", LINE_W'(lookup_hit), LINE_W'(h >= 0));
      if (h >= 0) begin
         chk(lookup_data === m_data[h], lbl, "lookup_data", lookup_data, m_data[h]);
         chk(lookup_dirty === m_dirty[h], lbl, "lookup_dirty", LINE_W'(lookup_dirty), LINE_W'(m_dirty[h]));
      end
      exp_wbv = 1'b0;
      if (h >= 0) begin
         m_remove(h);
         if (ev) m_push(ea, edat, ed);
      end else if (ev) begin
         if (m_n == NENT) begin
            exp_wbv = m_dirty[NENT-1];
            exp_wba = m_addr[NENT-1];
            exp_wbd = m_data[NENT-1];
            m_remove(NENT - 1);
         end
         m_push(ea, edat, ed);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed_0c4e));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: empty after reset
      step(1, pa(0), 0, '0, 0, "R1");
      step(1, pa(3), 0, '0, 0, "R1");

      // R4: fill without writeback; R3 partial-address aliases miss
      step(0, '0, 1, pa(0), 1, "R4");
      step(1, {pa(0)[ADDR_W-1:IDX_W], pa(0)[IDX_W-1:0] ^ IDX_W'(1)}, 0, '0, 0, "R3");
      step(1, {pa(0)[ADDR_W-1:IDX_W] ^ TAG_W'(1), pa(0)[IDX_W-1:0]}, 0, '0, 0, "R3");
      step(0, '0, 1, pa(1), 0, "R4");
      step(0, '0, 1, pa(2), 1, "R4");
      step(0, '0, 1, pa(3), 0, "R4");
      step(0, '0, 0, '0, 0, "R4");

      // R9: idle lookup of a held line, then confirm it is still held later
      step(0, pa(2), 0, '0, 0, "R9");

      // R5/R6: dirty oldest spills, clean next-oldest is dropped
      step(0, '0, 1, pa(4), 0, "R6");
      step(0, '0, 1, pa(5), 0, "R6");
      step(0, '0, 0, '0, 0, "R6");
      step(1, pa(0), 0, '0, 0, "R5");
      step(1, pa(1), 0, '0, 0, "R5");

      // R7: swap, no writeback, neighbours kept
      step(1, pa(2), 1, pa(6), 0, "R7");
      step(1, pa(3), 1, pa(7), 1, "R7");
      step(1, pa(4), 0, '0, 0, "R7");
      // R8: hit without insert removes the line
      step(1, pa(6), 0, '0, 0, "R8");
      step(1, pa(6), 0, '0, 0, "R8");
      step(1, pa(2), 0, '0, 0, "R8");

      // mixed random traffic
      for (int n = 0; n < 1500; n++) begin
         bit lv, ev, ed;
         logic [ADDR_W-1:0] la, ea;
         int hh;
         string lbl;
         lv = ($urandom % 4) != 0;
         la = pa($urandom % 8);
         ev = $urandom % 2;
         ea = pa($urandom % 8);
         ed = $urandom % 2;
         if (ev && m_find(ea) >= 0) ev = 0;
         hh = lv ? m_find(la) : -1;
         if (!lv)                  lbl = "R9";
         else if (hh >= 0 && ev)   lbl = "R7";
         else if (hh >= 0)         lbl = "R2";
         else                      lbl = "R5";
         step(lv, la, ev, ea, ed, lbl);
      end
      step(0, '0, 0, '0, 0, "R6");
      finish_run();
   end
endmodule